// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by reading a two-level table from memory. The table root is a base address that software programs. A request port accepts one address at a time. A single-word memory read port fetches table entries. A response port returns one of three results: the translated address with the page's 4-bit authority index, a first-level fault, or a second-level fault. A fault carries the address that failed.

The address splits into three fields. Bits 31:20 index the 4096-entry first level. Bits 19:12 index the 256-entry second level. Bits 11:0 are the byte offset inside a 4 KiB page. A four-entry, fully associative cache keeps completed translations, keyed by bits 31:12, and replaces them in round-robin order. Software empties the cache through a flush register whose bits clear themselves, so software can poll for completion. While translation is disabled, addresses pass straight through.

Top module: `iova_walker`

## Requirements
- R1: On a cache miss with translation enabled, the first memory read goes to `cfg_base + 4 * req_addr[31:20]`.
- R2: After a valid first-level entry E, the second read goes to `{E[31:10], req_addr[19:12], 2'b00}`.
- R3: A first-level entry is valid only when bits 1:0 equal 2'b01. Any other value ends the walk after one read, with `rsp_fault_l1`=1, `rsp_fault_l2`=0 and `rsp_fault_addr` equal to the request address.
- R4: A second-level entry with bit 1 clear gives `rsp_fault_l2`=1, `rsp_fault_l1`=0 and `rsp_fault_addr` equal to the request address, after two reads.
- R5: With a valid second-level entry P, the response is `rsp_paddr = {P[31:12], req_addr[11:0]}` and `rsp_aci = P[7:4]`, with both fault flags low.
- R6: Only one walk is outstanding at a time. `req_ready` stays low from the cycle after acceptance until the response. Each memory read is a one-cycle `mem_rd_en` pulse.
- R7: A page translated before answers one cycle after acceptance with no memory read. The cache holds four pages and replaces them in round-robin order, so a fifth new page evicts the oldest.
- R8: While `cfg_enable` is 0, the response comes one cycle after acceptance with `rsp_paddr` = `req_addr`, `rsp_aci` = 0, no fault and no memory read.
- R9: A flush write sets only bits 17 (walk cache), 16 (main TLB) and 5:0 (per-master) of `flush_stat`. Writes to other bits are ignored. A set bit is visible one cycle after the write edge and reads zero two cycles after that.
- R10: After a flush, a page that was cached needs a full two-read walk again.
- R11: A walk that a flush overlaps still returns its result but does not fill the cache.
- R12: Faulting walks are not cached. Repeating a faulting address walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Translation enable (0 = pass-through) |
| cfg_base | input | 32 | First-level table base address |
| flush_wr | input | 1 | Flush register write strobe |
| flush_wdata | input | 32 | Flush register write data |
| flush_stat | output | 32 | Flush bits still pending |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | I/O virtual address |
| req_ready | output | 1 | Walker idle, request accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_aci | output | 4 | Authority control index of the page |
| rsp_fault_l1 | output | 1 | First-level entry invalid |
| rsp_fault_l2 | output | 1 | Second-level entry invalid |
| rsp_fault_addr | output | 32 | Faulting virtual address (0 when no fault) |
| mem_rd_en | output | 1 | Table entry read request pulse |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Table entry word |

## Verification
A wrong cache state is visible at the ports on the very next request to the same page. A stale or missing entry changes the read count from zero to two, or the reverse, and the response comes several cycles later than the one cycle expected. A bad walk state shows up on the next memory read: either the fetch address misses its expected field concatenation, or a response arrives without the expected read count. A broken flush state shows within three cycles of the write, either as pending bits that never clear or as a cached page that still hits afterwards.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
  localparam int ENTRY_W = 32;
  localparam logic [1:0] L1_VALID_CODE = 2'b01;
  localparam int L2_VALID_BIT = 1;

  typedef enum logic [1:0] {WS_IDLE, WS_L1, WS_L2} walk_state_t;

  function automatic logic l1_entry_ok(input logic [ENTRY_W-1:0] e);
    return e[1:0] == L1_VALID_CODE;
  endfunction

  function automatic logic l2_entry_ok(input logic [ENTRY_W-1:0] e);
    return e[L2_VALID_BIT];
  endfunction
endpackage

// File: rtl/iova_walk_flush.sv
module iova_walk_flush #(
  parameter int DATA_W  = 32,
  parameter int MASTERS = 6,
  parameter int MAIN_BIT = 16,
  parameter int WALK_BIT = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat,
  output logic              inv
);
  localparam logic [DATA_W-1:0] MASK =
    (DATA_W'(1) << WALK_BIT) | (DATA_W'(1) << MAIN_BIT) | ((DATA_W'(1) << MASTERS) - DATA_W'(1));

  logic phase;

  // invalidate strobe in the first cycle that a bit is pending
  assign inv = (stat != '0) && !phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      phase <= 1'b0;
    end else if (phase) begin
      stat  <= wr ? (wdata & MASK) : '0;
      phase <= 1'b0;
    end else begin
      if (wr) stat <= stat | (wdata & MASK);
      if (inv) phase <= 1'b1;
    end
  end

  assert_inv_then_phase_R9: assert property (@(posedge clk) disable iff (rst) inv |=> phase);
  assert_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
    (phase && !wr) |=> (stat == '0));
  assert_masked_R9: assert property (@(posedge clk) disable iff (rst) (stat & ~MASK) == '0);
endmodule

// File: rtl/iova_walk_cache.sv
module iova_walk_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20,
  parameter int ACI_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [ACI_W-1:0]   lk_aci,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [ACI_W-1:0]   fill_aci
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ACI_W-1:0]   aci_q   [ENTRIES];
  logic [PTR_W-1:0]   ptr;
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (tag_q[i] == lk_tag);
  end

  always_comb begin
    lk_frame = '0;
    lk_aci   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_frame = frame_q[i];
        lk_aci   = aci_q[i];
      end
    end
  end
  assign lk_hit = |hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (fill_en && !inv && ptr == PTR_W'(i)) begin
        tag_q[i]   <= fill_tag;
        frame_q[i] <= fill_frame;
        aci_q[i]   <= fill_aci;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      ptr   <= '0;
    end else if (inv) begin
      valid <= '0;
    end else if (fill_en) begin
      valid[ptr] <= 1'b1;
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  assert_single_hit_R7: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst) inv |=> !lk_hit);
endmodule

// File: rtl/iova_walk_fsm.sv
module iova_walk_fsm
  import iova_walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_BITS  = 12,
  parameter int L2_BITS  = 8,
  parameter int OFF_BITS = 12,
  parameter int ACI_W    = 4,
  parameter int ACI_LSB  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  input  logic [ADDR_W-1:0]              base,
  input  logic                           inv,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic                           req_ready,
  output logic [L1_BITS+L2_BITS-1:0]     lk_tag,
  input  logic                           lk_hit,
  input  logic [ADDR_W-OFF_BITS-1:0]     lk_frame,
  input  logic [ACI_W-1:0]               lk_aci,
  output logic                           fill_en,
  output logic [L1_BITS+L2_BITS-1:0]     fill_tag,
  output logic [ADDR_W-OFF_BITS-1:0]     fill_frame,
  output logic [ACI_W-1:0]               fill_aci,
  output logic                           mem_rd_en,
  output logic [ADDR_W-1:0]              mem_rd_addr,
  input  logic                           mem_rd_valid,
  input  logic [ADDR_W-1:0]              mem_rd_data,
  output logic                           rsp_valid,
  output logic [ADDR_W-1:0]              rsp_paddr,
  output logic [ACI_W-1:0]               rsp_aci,
  output logic                           rsp_fault_l1,
  output logic                           rsp_fault_l2,
  output logic [ADDR_W-1:0]              rsp_fault_addr
);
  localparam int TAG_W   = L1_BITS + L2_BITS;
  localparam int FRAME_W = ADDR_W - OFF_BITS;
  localparam int PT_LSB  = L2_BITS + 2;

  walk_state_t       state;
  logic [ADDR_W-1:0] cur_addr;
  logic              stale;
  logic              pte_ok;

  assign req_ready = (state == WS_IDLE);
  assign lk_tag    = req_addr[ADDR_W-1:OFF_BITS];
  assign pte_ok    = l2_entry_ok(mem_rd_data);

  // fill in the same edge as the response so a back-to-back request hits
  assign fill_en    = (state == WS_L2) && mem_rd_valid && pte_ok && !stale && !inv;
  assign fill_tag   = cur_addr[ADDR_W-1:OFF_BITS];
  assign fill_frame = mem_rd_data[ADDR_W-1:OFF_BITS];
  assign fill_aci   = mem_rd_data[ACI_LSB +: ACI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= WS_IDLE;
      cur_addr       <= '0;
      stale          <= 1'b0;
      mem_rd_en      <= 1'b0;
      mem_rd_addr    <= '0;
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_aci        <= '0;
      rsp_fault_l1   <= 1'b0;
      rsp_fault_l2   <= 1'b0;
      rsp_fault_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_rd_en <= 1'b0;
      if (inv) stale <= 1'b1;
      unique case (state)
        WS_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            stale    <= 1'b0;
            if (!enable) begin
              rsp_valid      <= 1'b1;
              rsp_paddr      <= req_addr;
              rsp_aci        <= '0;
              rsp_fault_l1   <= 1'b0;
              rsp_fault_l2   <= 1'b0;
              rsp_fault_addr <= '0;
            end else if (lk_hit) begin
              rsp_valid      <= 1'b1;
              rsp_paddr      <= {lk_frame, req_addr[OFF_BITS-1:0]};
              rsp_aci        <= lk_aci;
              rsp_fault_l1   <= 1'b0;
              rsp_fault_l2   <= 1'b0;
              rsp_fault_addr <= '0;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= base + ADDR_W'({req_addr[ADDR_W-1 -: L1_BITS], 2'b00});
              state       <= WS_L1;
            end
          end
        end
        WS_L1: begin
          if (mem_rd_valid) begin
            if (l1_entry_ok(mem_rd_data)) begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= {mem_rd_data[ADDR_W-1:PT_LSB], cur_addr[OFF_BITS +: L2_BITS], 2'b00};
              state       <= WS_L2;
            end else begin
              rsp_valid      <= 1'b1;
              rsp_paddr      <= '0;
              rsp_aci        <= '0;
              rsp_fault_l1   <= 1'b1;
              rsp_fault_l2   <= 1'b0;
              rsp_fault_addr <= cur_addr;
              state          <= WS_IDLE;
            end
          end
        end
        WS_L2: begin
          if (mem_rd_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault_l1 <= 1'b0;
            if (pte_ok) begin
              rsp_paddr      <= {mem_rd_data[ADDR_W-1:OFF_BITS], cur_addr[OFF_BITS-1:0]};
              rsp_aci        <= mem_rd_data[ACI_LSB +: ACI_W];
              rsp_fault_l2   <= 1'b0;
              rsp_fault_addr <= '0;
            end else begin
              rsp_paddr      <= '0;
              rsp_aci        <= '0;
              rsp_fault_l2   <= 1'b1;
              rsp_fault_addr <= cur_addr;
            end
            state <= WS_IDLE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assert_one_walk_R6: assert property (@(posedge clk) disable iff (rst) mem_rd_en |-> !req_ready);
  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> !mem_rd_en);
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !enable) |=>
      (rsp_valid && rsp_paddr == $past(req_addr) && !rsp_fault_l1 && !rsp_fault_l2 && !mem_rd_en));
  assert_hit_nomem_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && enable && lk_hit) |=> (rsp_valid && !mem_rd_en));
  assert_fault_excl_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_fault_l1 && rsp_fault_l2));
  assert_l1_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (state == WS_L1 && mem_rd_valid && mem_rd_data[1:0] != 2'b01) |=> (rsp_fault_l1 && !mem_rd_en));
  assert_no_fill_stale_R11: assert property (@(posedge clk) disable iff (rst) fill_en |-> !stale);
  assert_fault_nofill_R12: assert property (@(posedge clk) disable iff (rst) fill_en |=> !rsp_fault_l2);
endmodule

// File: rtl/iova_walker.sv
module iova_walker #(
  parameter int ADDR_W   = 32,
  parameter int L1_BITS  = 12,
  parameter int L2_BITS  = 8,
  parameter int ACI_W    = 4,
  parameter int ACI_LSB  = 4,
  parameter int CACHE_N  = 4,
  parameter int MASTERS  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              flush_wr,
  input  logic [ADDR_W-1:0] flush_wdata,
  output logic [ADDR_W-1:0] flush_stat,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ACI_W-1:0]  rsp_aci,
  output logic              rsp_fault_l1,
  output logic              rsp_fault_l2,
  output logic [ADDR_W-1:0] rsp_fault_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data
);
  localparam int OFF_BITS = ADDR_W - L1_BITS - L2_BITS;
  localparam int TAG_W    = L1_BITS + L2_BITS;
  localparam int FRAME_W  = ADDR_W - OFF_BITS;

  logic               inv;
  logic [TAG_W-1:0]   lk_tag, fill_tag;
  logic               lk_hit, fill_en;
  logic [FRAME_W-1:0] lk_frame, fill_frame;
  logic [ACI_W-1:0]   lk_aci, fill_aci;

  iova_walk_flush #(.DATA_W(ADDR_W), .MASTERS(MASTERS)) u_flush (
    .clk(clk), .rst(rst), .wr(flush_wr), .wdata(flush_wdata), .stat(flush_stat), .inv(inv)
  );

  iova_walk_cache #(.ENTRIES(CACHE_N), .TAG_W(TAG_W), .FRAME_W(FRAME_W), .ACI_W(ACI_W)) u_cache (
    .clk(clk), .rst(rst), .inv(inv),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_aci(lk_aci),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame), .fill_aci(fill_aci)
  );

  iova_walk_fsm #(.ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS),
                  .ACI_W(ACI_W), .ACI_LSB(ACI_LSB)) u_fsm (
    .clk(clk), .rst(rst), .enable(cfg_enable), .base(cfg_base), .inv(inv),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_aci(lk_aci),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame), .fill_aci(fill_aci),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_aci(rsp_aci),
    .rsp_fault_l1(rsp_fault_l1), .rsp_fault_l2(rsp_fault_l2), .rsp_fault_addr(rsp_fault_addr)
  );
endmodule

// File: tb/tb_iova_walker.sv
module tb_iova_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [31:0] cfg_base = 32'h8000_0000;
  logic        flush_wr = 1'b0;
  logic [31:0] flush_wdata = '0;
  logic [31:0] flush_stat;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_fault_l1, rsp_fault_l2, mem_rd_en;
  logic [31:0] rsp_paddr, rsp_fault_addr, mem_rd_addr;
  logic [3:0]  rsp_aci;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  iova_walker dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  logic [31:0] mem_img [logic [31:0]];
  logic        p_v;
  logic [31:0] p_a;
  int          rd_cnt = 0;
  logic [31:0] rd_log [4];

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  // memory model: two-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      p_v <= 1'b0; p_a <= '0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
    end else begin
      mem_rd_valid <= p_v;
      mem_rd_data  <= rd_word(p_a);
      p_v <= mem_rd_en;
      p_a <= mem_rd_addr;
    end
  end

  always @(posedge clk) begin
    if (!rst && mem_rd_en) begin
      if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] r_pa, r_fa;
  logic [3:0]  r_aci;
  logic        r_f1, r_f2, r_busy_ok;
  int          r_lat, r_reads;

  task automatic do_req(input logic [31:0] a);
    @(negedge clk);
    rd_cnt = 0; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; r_lat = 1; r_busy_ok = 1'b1;
    while (!rsp_valid && r_lat < 50) begin
      if (req_ready) r_busy_ok = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    r_pa = rsp_paddr; r_aci = rsp_aci; r_f1 = rsp_fault_l1; r_f2 = rsp_fault_l2;
    r_fa = rsp_fault_addr; r_reads = rd_cnt;
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] a);
    return cfg_base + {18'h0, a[31:20], 2'b00};
  endfunction

  localparam logic [31:0] PT = 32'h0040_0000;

  function automatic logic [31:0] pte_of(input int k);
    return {20'h10000 + 20'(k), 4'h0, 4'(k), 4'h2};
  endfunction

  function automatic logic [31:0] page_of(input int k);
    return {12'h123, 8'(k), 12'habc};
  endfunction

  task automatic t_reset;
    chk(req_ready == 1'b1, "reset req_ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "reset rsp_valid", 32'(rsp_valid), 32'h0);
    chk(mem_rd_en == 1'b0, "reset mem_rd_en", 32'(mem_rd_en), 32'h0);
    chk(flush_stat == 32'h0, "reset flush_stat R9", flush_stat, 32'h0);
  endtask

  task automatic t_walk_ok;
    logic [31:0] a = 32'h1234_5678;
    do_req(a);
    chk(r_reads == 2, "R6 walk read count", 32'(r_reads), 32'd2);
    chk(rd_log[0] == l1_addr(a), "R1 first-level fetch address", rd_log[0], l1_addr(a));
    chk(rd_log[1] == PT + 32'h114, "R2 second-level fetch address", rd_log[1], PT + 32'h114);
    chk(r_pa == 32'hABCD_E678, "R5 translated address", r_pa, 32'hABCD_E678);
    chk(r_aci == 4'h5 && !r_f1 && !r_f2, "R5 aci and no fault", {r_aci, 26'h0, r_f1, r_f2}, {4'h5, 28'h0});
    chk(r_busy_ok, "R6 ready low during walk", 32'(r_busy_ok), 32'h1);
  endtask

  task automatic t_hit;
    do_req(32'h1234_5001);
    chk(r_lat == 1 && r_reads == 0, "R7 cache hit latency/reads", 32'(r_lat * 16 + r_reads), 32'h10);
    chk(r_pa == 32'hABCD_E001, "R7 cache hit address", r_pa, 32'hABCD_E001);
  endtask

  task automatic t_l1_faults;
    for (int i = 1; i <= 3; i++) begin
      logic [31:0] a = {12'(i), 20'h0_4321};
      do_req(a);
      chk(r_f1 && !r_f2, "R3 first-level fault flags", {30'h0, r_f1, r_f2}, 32'h2);
      chk(r_fa == a && r_reads == 1, "R3 fault addr and single read", r_fa, a);
    end
  endtask

  task automatic t_l2_faults;
    for (int k = 1; k <= 2; k++) begin
      do_req(page_of(k));
      chk(!r_f1 && r_f2, "R4 second-level fault flags", {30'h0, r_f1, r_f2}, 32'h1);
      chk(r_fa == page_of(k) && r_reads == 2, "R4 fault addr and two reads", r_fa, page_of(k));
    end
    do_req(page_of(1));
    chk(r_f2 && r_reads == 2, "R12 fault not cached", 32'(r_reads), 32'd2);
  endtask

  task automatic t_bypass;
    cfg_enable = 1'b0;
    do_req(32'hDEAD_BEEF);
    chk(r_pa == 32'hDEAD_BEEF && r_lat == 1, "R8 pass-through address", r_pa, 32'hDEAD_BEEF);
    chk(r_reads == 0 && !r_f1 && !r_f2 && r_aci == 0, "R8 no read no fault", 32'(r_reads), 32'h0);
    do_req(32'h1234_5678);
    chk(r_pa == 32'h1234_5678, "R8 cached page ignored when disabled", r_pa, 32'h1234_5678);
    cfg_enable = 1'b1;
  endtask

  task automatic t_evict;
    for (int k = 3; k <= 6; k++) begin
      do_req(page_of(k));
      chk(r_reads == 2 && r_pa == {pte_of(k)[31:12], 12'habc}, "R7 fill page", r_pa, {pte_of(k)[31:12], 12'habc});
    end
    do_req(page_of(4));
    chk(r_reads == 0 && r_aci == 4'h4, "R7 retained page hits", 32'(r_reads), 32'h0);
    do_req(32'h1234_5678);
    chk(r_reads == 2, "R7 oldest page evicted", 32'(r_reads), 32'd2);
  endtask

  task automatic flush_write(input logic [31:0] d);
    @(negedge clk);
    flush_wr = 1'b1; flush_wdata = d;
    @(negedge clk);
    flush_wr = 1'b0;
  endtask

  task automatic t_flush;
    flush_write(32'hFFFC_FFC0);
    chk(flush_stat == 0, "R9 unmapped bits ignored", flush_stat, 32'h0);
    do_req(32'h1234_5678);
    chk(r_reads == 0, "R9 ignored write keeps cache", 32'(r_reads), 32'h0);
    flush_write(32'hFFFF_FFFF);
    chk(flush_stat == 32'h0003_003F, "R9 flush bits set", flush_stat, 32'h0003_003F);
    @(negedge clk);
    chk(flush_stat == 32'h0003_003F, "R9 flush bits still pending", flush_stat, 32'h0003_003F);
    @(negedge clk);
    chk(flush_stat == 32'h0, "R9 flush bits self-clear", flush_stat, 32'h0);
    do_req(32'h1234_5678);
    chk(r_reads == 2 && r_pa == 32'hABCD_E678, "R10 walk again after flush", 32'(r_reads), 32'd2);
    flush_write(32'h0000_0008);
    chk(flush_stat == 32'h8, "R9 single master bit", flush_stat, 32'h8);
    repeat (2) @(negedge clk);
    chk(flush_stat == 32'h0, "R9 single bit clears", flush_stat, 32'h0);
  endtask

  task automatic t_flush_during_walk;
    @(negedge clk);
    rd_cnt = 0; req_valid = 1'b1; req_addr = page_of(5);
    @(negedge clk);
    req_valid = 1'b0; flush_wr = 1'b1; flush_wdata = 32'h0001_0000;
    @(negedge clk);
    flush_wr = 1'b0;
    for (int i = 0; i < 50 && !rsp_valid; i++) @(negedge clk);
    chk(rsp_paddr == {pte_of(5)[31:12], 12'habc}, "R11 overlapped walk result", rsp_paddr,
        {pte_of(5)[31:12], 12'habc});
    do_req(page_of(5));
    chk(r_reads == 2, "R11 overlapped walk not cached", 32'(r_reads), 32'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mem_img[cfg_base + 32'h48C] = 32'h0040_0001;
    mem_img[cfg_base + 32'h004] = 32'h0040_0003;
    mem_img[cfg_base + 32'h008] = 32'h0040_0002;
    mem_img[PT + 32'h114] = 32'hABCD_E052;
    mem_img[PT + 32'h008] = 32'h1111_1FF1;
    for (int k = 3; k <= 6; k++) mem_img[PT + 32'(k * 4)] = pte_of(k);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg_enable = 1'b1;
    t_walk_ok();
    t_hit();
    t_l1_faults();
    t_l2_faults();
    t_bypass();
    t_evict();
    t_flush();
    t_flush_during_walk();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule